// File: doc/BRIEF.md
# I2C Register-Map Target with Masked Alert

This block is a target on a two-wire serial bus. It presents a 32-byte register map to an external bus controller. The controller names a register by writing a pointer byte first. It then streams data bytes in or out, and the pointer moves forward after every byte. The lower half of the map can only be read. It carries a status byte, which local logic drives, and a set of 16-bit measurement words. The upper half can be read and written by the controller. It holds an interrupt mask byte followed by general control bytes, and these bytes are also brought out to the local logic.

Local application logic writes each 16-bit word in a single clock cycle. When the controller reads the low byte of a word, the block takes a copy of that word. The high byte that follows is served from the copy, so a word read low-then-high never mixes two updates. An open-drain alert output pulls low whenever a status bit is set and its mask bit is enabled. This spares the controller from polling the block.

The bus lines are sampled with the system clock through synchronizer flops. The block only ever pulls a line low or lets it go. It acknowledges its own address and every data byte, but it never stretches the clock and never arbitrates.

Top module: `i2c_regmap_target`

## Requirements
- R1: Both outputs are pull-low enables (1 means pull low). After reset and after any STOP the data pull is released, and after reset the alert pull is released.
- R2: The block pulls data low during the ninth clock of an address byte whose upper seven bits equal the address parameter. For any other address it leaves data released, and it ignores the rest of that transaction until the next START.
- R3: In a write transaction, the first data byte loads the pointer from its low five bits. Each later byte is stored at the pointer, and the pointer then advances by one, wrapping from 0x1F to 0x00.
- R4: After a pointer write and a repeated START with the read bit (address LSB = 1), the block returns the byte at the pointer and then each following byte, wrapping at 0x1F. It releases data once the controller answers a byte with no-acknowledge.
- R5: Bytes written to 0x00–0x0F are acknowledged and leave the register unchanged, but they still advance the pointer.
- R6: Address 0x00 returns the local status input, registered once. Address 0x10 is the mask. The alert pull is set exactly when (status AND mask) is non-zero.
- R7: Word k (k = 0..3) is read with its low byte at 0x02+2k and its high byte at 0x03+2k. The local port replaces both bytes in one cycle. Addresses 0x01 and 0x0A–0x0F read as 0x00.
- R8: Reading the low byte of a word copies that word. A following read of its high byte returns the copied value, even if the local port updated the word in between.
- R9: A START or STOP in the middle of a byte abandons that byte: nothing is written and the pointer is unchanged. A START then begins a fresh address phase.
- R10: The control bytes 0x10–0x1F reset to 0x00 and appear on cfg_bytes, with byte 0x10+i at bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 pulls the data line low |
| alert_pull_low | output | 1 | 1 pulls the alert line low |
| app_status | input | 8 | Live status flags from local logic |
| app_we | input | 1 | Local word write strobe |
| app_idx | input | 2 | Local word index |
| app_word | input | 16 | Local word value |
| cfg_bytes | output | 128 | Control bytes 0x10..0x1F, flattened |

## Verification
The bench builds the block with the address parameter set to 0x2C rather than its default, so a match against a non-default value is exercised, and a neighbouring address differing in bit 0 must be ignored. It keeps the 32-byte map and four words. This puts the pointer wrap from 0x1F into the read-only status byte within a two-byte transfer, and it lets a single ten-byte read cover all words and both unused read-only gaps. Four words make it possible to update a word in the middle of a read while the other words stay fixed.

// File: rtl/i2crm_pkg.sv
// Shared types for the register-map target.
// Assumes: used by all modules of the i2c_regmap_target hierarchy.
package i2crm_pkg;

    // Byte-level protocol phases of the bus engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    localparam int BYTE_W = 8;
    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2crm_line_sync.sv
// Brings the two bus lines into the clock domain and derives edge and
// condition strobes from the synchronized levels.
// Assumes: SYNC_STAGES >= 2; the bus clock is slow enough that every bus
// level lasts several system clocks.
module i2crm_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LANES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] now_lvl;
    logic [LANES-1:0] prev_lvl;

    assign raw = {sda_in, scl_in};

    // One synchronizer chain per line.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SYNC_STAGES-1:0] pipe;

        // Shift the raw line level through the synchronizer; idle bus is high.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
            end
        end

        assign now_lvl[g] = pipe[SYNC_STAGES-1];
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= '1;
        end else begin
            prev_lvl <= now_lvl;
        end
    end

    assign sda_lvl   = now_lvl[L_SDA];
    assign scl_rise  = now_lvl[L_SCL] & ~prev_lvl[L_SCL];
    assign scl_fall  = ~now_lvl[L_SCL] & prev_lvl[L_SCL];
    assign start_det = now_lvl[L_SCL] & prev_lvl[L_SCL] & prev_lvl[L_SDA] & ~now_lvl[L_SDA];
    assign stop_det  = now_lvl[L_SCL] & prev_lvl[L_SCL] & ~prev_lvl[L_SDA] & now_lvl[L_SDA];

endmodule

// File: rtl/i2crm_bus_engine.sv
// Byte engine of the target: address match, acknowledge, pointer load and
// advance, and bit shifting in both directions. It issues one write strobe
// per stored data byte and one load strobe per transmitted byte.
// Assumes: strobes come from i2crm_line_sync; data changes only after a
// detected clock fall; read data is combinational on rd_addr.
module i2crm_bus_engine
    import i2crm_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         PTR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_load,
    output logic [PTR_W-1:0]  rd_addr
);
    localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE);

    bus_state_e          state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [PTR_W-1:0]    ptr;
    logic                is_read;
    logic                ptr_phase;
    logic                nack_seen;
    logic                byte_done;
    logic                bus_cond;

    assign bus_cond  = start_det | stop_det;
    assign byte_done = scl_fall && (bit_cnt == LAST_BIT) && !bus_cond;

    // Strobes towards the register file.
    assign wr_en   = (state == ST_RX) && byte_done && !ptr_phase;
    assign wr_addr = ptr;
    assign wr_data = rx_sh;
    assign rd_addr = ptr;
    assign rd_load = scl_fall && !bus_cond &&
                     (((state == ST_ADDR_ACK) && is_read) ||
                      ((state == ST_TX_ACK) && !nack_seen));

    // Protocol sequencing: conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            ptr_phase <= 1'b0;
            nack_seen <= 1'b0;
            sda_pull  <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sda_pull <= 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        if (rx_sh[BYTE_W-1:1] == DEV_ADDR) begin
                            state    <= ST_ADDR_ACK;
                            sda_pull <= 1'b1;
                            is_read  <= rx_sh[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            state    <= ST_TX;
                            tx_sh    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                        end else begin
                            state     <= ST_RX;
                            sda_pull  <= 1'b0;
                            ptr_phase <= 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        state    <= ST_RX_ACK;
                        sda_pull <= 1'b1;
                        if (ptr_phase) begin
                            ptr       <= rx_sh[PTR_W-1:0];
                            ptr_phase <= 1'b0;
                        end else begin
                            ptr <= ptr + PTR_W'(1);
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        state    <= ST_RX;
                        bit_cnt  <= '0;
                        sda_pull <= 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (byte_done) begin
                        state    <= ST_TX_ACK;
                        sda_pull <= 1'b0;
                        ptr      <= ptr + PTR_W'(1);
                    end else if (scl_fall) begin
                        tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~tx_sh[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        nack_seen <= sda_lvl;
                    end else if (scl_fall) begin
                        if (nack_seen) begin
                            state <= ST_IDLE;
                        end else begin
                            state    <= ST_TX;
                            bit_cnt  <= '0;
                            tx_sh    <= rd_data;
                            sda_pull <= ~rd_data[BYTE_W-1];
                        end
                    end
                end
                default: begin
                    state    <= ST_IDLE;
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2crm_regfile.sv
// Register map: status byte and 16-bit words in the lower (read-only) half,
// mask and control bytes in the upper (read/write) half, per-word high-byte
// copies for coherent reads, and the masked alert.
// Assumes: MAP_DEPTH is a power of two so the top pointer bit selects the
// half; words fit below the half boundary starting at WORD_BASE.
module i2crm_regfile
    import i2crm_pkg::*;
#(
    parameter int MAP_DEPTH = 32,
    parameter int NUM_WORDS = 4,
    parameter int WORD_BASE = 2,
    parameter int STAT_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [STAT_W-1:0]              app_status,
    input  logic                           app_we,
    input  logic [$clog2(NUM_WORDS)-1:0]   app_idx,
    input  logic [15:0]                    app_word,
    input  logic                           wr_en,
    input  logic [$clog2(MAP_DEPTH)-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic                           rd_load,
    input  logic [$clog2(MAP_DEPTH)-1:0]   rd_addr,
    output logic [BYTE_W-1:0]              rd_data,
    output logic [(MAP_DEPTH/2)*BYTE_W-1:0] cfg_bytes,
    output logic                           alert_pull
);
    localparam int PTR_W    = $clog2(MAP_DEPTH);
    localparam int RW_BYTES = MAP_DEPTH / 2;
    localparam int RW_W     = PTR_W - 1;
    localparam int IDX_W    = $clog2(NUM_WORDS);

    logic [STAT_W-1:0] stat_q;
    logic [15:0]       live_q   [NUM_WORDS];
    logic [7:0]        shadow_q [NUM_WORDS];
    logic [BYTE_W-1:0] rw_q     [RW_BYTES];
    logic              alert_q;

    // Register the local status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= app_status;
        end
    end

    // Local word updates (both bytes at once) and high-byte capture on a low-byte load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                live_q[k]   <= '0;
                shadow_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (app_we && (app_idx == IDX_W'(k))) begin
                    live_q[k] <= app_word;
                end
                if (rd_load && (rd_addr == PTR_W'(WORD_BASE + 2 * k))) begin
                    shadow_q[k] <= live_q[k][15:8];
                end
            end
        end
    end

    // Bus writes land only in the upper half of the map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RW_BYTES; i++) begin
                rw_q[i] <= '0;
            end
        end else if (wr_en && wr_addr[PTR_W-1]) begin
            rw_q[wr_addr[RW_W-1:0]] <= wr_data;
        end
    end

    // Select the byte addressed by the pointer.
    always_comb begin
        rd_data = '0;
        if (rd_addr[PTR_W-1]) begin
            rd_data = rw_q[rd_addr[RW_W-1:0]];
        end else if (rd_addr == '0) begin
            rd_data[STAT_W-1:0] = stat_q;
        end else begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (rd_addr == PTR_W'(WORD_BASE + 2 * k)) begin
                    rd_data = live_q[k][7:0];
                end
                if (rd_addr == PTR_W'(WORD_BASE + 2 * k + 1)) begin
                    rd_data = shadow_q[k];
                end
            end
        end
    end

    // Combine enabled status bits into a registered alert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else begin
            alert_q <= |(stat_q & rw_q[0][STAT_W-1:0]);
        end
    end

    assign alert_pull = alert_q;

    for (genvar i = 0; i < RW_BYTES; i++) begin : g_cfg
        assign cfg_bytes[i*BYTE_W +: BYTE_W] = rw_q[i];
    end

endmodule

// File: rtl/i2c_regmap_target.sv
// Top of the two-wire register-map target: line synchronizer, byte engine
// and register file, with open-drain style pull-low outputs.
// Assumes: external pull-ups on all lines; the bus clock holds each level
// for at least SYNC_STAGES+3 system clocks; STAT_W <= 8; MAP_DEPTH is a
// power of two with 2 + 2*NUM_WORDS <= MAP_DEPTH/2.
module i2c_regmap_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         MAP_DEPTH   = 32,
    parameter int         NUM_WORDS   = 4,
    parameter int         STAT_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scl_in,
    input  logic                           sda_in,
    output logic                           sda_pull_low,
    output logic                           alert_pull_low,
    input  logic [STAT_W-1:0]              app_status,
    input  logic                           app_we,
    input  logic [$clog2(NUM_WORDS)-1:0]   app_idx,
    input  logic [15:0]                    app_word,
    output logic [(MAP_DEPTH/2)*8-1:0]     cfg_bytes
);
    localparam int PTR_W     = $clog2(MAP_DEPTH);
    localparam int WORD_BASE = 2;

    logic             sda_lvl;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic             rd_load;
    logic [PTR_W-1:0] rd_addr;
    logic [7:0]       rd_data;

    i2crm_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2crm_bus_engine #(
        .DEV_ADDR (DEV_ADDR),
        .PTR_W    (PTR_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_pull  (sda_pull_low),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .rd_addr   (rd_addr)
    );

    i2crm_regfile #(
        .MAP_DEPTH (MAP_DEPTH),
        .NUM_WORDS (NUM_WORDS),
        .WORD_BASE (WORD_BASE),
        .STAT_W    (STAT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .app_status (app_status),
        .app_we     (app_we),
        .app_idx    (app_idx),
        .app_word   (app_word),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_load    (rd_load),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cfg_bytes  (cfg_bytes),
        .alert_pull (alert_pull_low)
    );

endmodule

// File: rtl/i2crm_checker.sv
// Protocol and register-map properties of i2c_regmap_target, bound to it.
// Assumes: the bound top drives the named internal strobes.
module i2crm_checker #(
    parameter int PTR_W     = 5,
    parameter int MAP_DEPTH = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_det,
    input logic                          stop_det,
    input logic                          sda_pull_low,
    input logic                          alert_pull_low,
    input logic                          wr_en,
    input logic [PTR_W-1:0]              wr_addr,
    input logic [7:0]                    wr_data,
    input logic                          rd_load,
    input logic [(MAP_DEPTH/2)*8-1:0]    cfg_bytes
);
    // R1: a STOP always leaves the data line released.
    a_r1_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_low);

    // R9: a START restarts the address phase with the data line released.
    a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_low);

    // R3/R4: a byte slot is either stored or loaded, never both.
    a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_load}));

    // R5: a write aimed at the lower half changes no control byte.
    a_r5_ro_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[PTR_W-1]) |=> $stable(cfg_bytes));

    // R3: a write aimed at the upper half lands at the pointer offset.
    a_r3_rw_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[PTR_W-1]) |=>
        (cfg_bytes[int'($past(wr_addr[PTR_W-2:0])) * 8 +: 8] == $past(wr_data)));

    // R6: with the mask held at zero the alert stays released.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_bytes[7:0] == 8'h00) && ($past(cfg_bytes[7:0]) == 8'h00)) |-> !alert_pull_low);

endmodule

bind i2c_regmap_target i2crm_checker #(
    .PTR_W     (PTR_W),
    .MAP_DEPTH (MAP_DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_det      (start_det),
    .stop_det       (stop_det),
    .sda_pull_low   (sda_pull_low),
    .alert_pull_low (alert_pull_low),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .wr_data        (wr_data),
    .rd_load        (rd_load),
    .cfg_bytes      (cfg_bytes)
);

// File: tb/i2c_regmap_target_tb.sv
// Bit-banged bus controller plus a behavioural model of the register map;
// idle-bus outputs are compared with the model on every clock.
module i2c_regmap_target_tb;
    localparam int         Q    = 8;
    localparam logic [6:0] ADR  = 7'h2C;
    localparam int         WDOG = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         dut_sda;
    logic         dut_alert;
    logic [7:0]   app_status = 8'h00;
    logic         app_we = 1'b0;
    logic [1:0]   app_idx = 2'd0;
    logic [15:0]  app_word = 16'h0000;
    logic [127:0] cfg_bytes;
    logic         sda_line;

    assign sda_line = m_sda & ~dut_sda;

    always #4 clk = ~clk;

    i2c_regmap_target #(
        .DEV_ADDR (ADR)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_in         (m_scl),
        .sda_in         (sda_line),
        .sda_pull_low   (dut_sda),
        .alert_pull_low (dut_alert),
        .app_status     (app_status),
        .app_we         (app_we),
        .app_idx        (app_idx),
        .app_word       (app_word),
        .cfg_bytes      (cfg_bytes)
    );

    // Reference model state.
    logic [7:0]  m_rw [16];
    logic [15:0] m_word [4];
    logic [7:0]  m_shadow [4];
    logic [7:0]  m_stat;
    int  checks = 0;
    int  errors = 0;
    bit  busy = 1'b1;
    bit  done = 1'b0;
    int  settle = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(input int a);
        if (a >= 16) return m_rw[a-16];
        if (a == 0) return m_stat;
        if (a >= 2 && a <= 9) begin
            if (a % 2 == 0) return m_word[(a-2)/2][7:0];
            return m_shadow[(a-3)/2];
        end
        return 8'h00;
    endfunction

    // Idle-bus comparison against the model on every clock (R1, R6).
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            if (settle < 4) settle++;
            else begin
                chk("R6 alert vs model", 128'(dut_alert), 128'(|(m_stat & m_rw[0])));
                chk("R1 idle data released", 128'(dut_sda), 128'd0);
            end
        end
    end

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0;
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            v[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic begin_txn();
        busy = 1'b1;
    endtask

    task automatic end_txn();
        busy = 1'b0;
        settle = 0;
    endtask

    // Pointer write plus up to three data bytes; model follows R3/R5.
    task automatic wr_seq(input int ptr, input int n, input logic [7:0] d0, d1, d2, input string tag);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        begin_txn();
        bus_start();
        put_byte({ADR, 1'b0}, ack);
        chk({tag, " R2 address ack"}, 128'(ack), 128'd1);
        put_byte(8'(ptr), ack);
        chk({tag, " R3 pointer ack"}, 128'(ack), 128'd1);
        for (int i = 0; i < n; i++) begin
            int a;
            put_byte(d[i], ack);
            chk({tag, " R5 data ack"}, 128'(ack), 128'd1);
            a = (ptr + i) % 32;
            if (a >= 16) m_rw[a-16] = d[i];
        end
        bus_stop();
        end_txn();
    endtask

    // Pointer write, repeated START, n reads with NAK on the last (R4).
    task automatic rd_seq(input int ptr, input int n, input string tag);
        logic ack;
        logic [7:0] v;
        begin_txn();
        bus_start();
        put_byte({ADR, 1'b0}, ack);
        put_byte(8'(ptr), ack);
        bus_start();
        put_byte({ADR, 1'b1}, ack);
        chk({tag, " R4 read address ack"}, 128'(ack), 128'd1);
        for (int i = 0; i < n; i++) begin
            int a;
            a = (ptr + i) % 32;
            if (a >= 2 && a <= 9 && a % 2 == 0) m_shadow[(a-2)/2] = m_word[(a-2)/2][15:8];
            get_byte(i == n - 1, v);
            chk($sformatf("%s R4 read byte @%0h", tag, a), 128'(v), 128'(exp_byte(a)));
        end
        bus_stop();
        end_txn();
    endtask

    task automatic app_put(input int idx, input logic [15:0] w);
        app_idx = 2'(idx); app_word = w; app_we = 1'b1;
        wq(1);
        app_we = 1'b0;
        m_word[idx] = w;
    endtask

    task automatic set_status(input logic [7:0] s);
        app_status = s;
        m_stat = s;
        settle = 0;
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        for (int i = 0; i < 16; i++) m_rw[i] = 8'h00;
        for (int k = 0; k < 4; k++) begin m_word[k] = 16'h0; m_shadow[k] = 8'h0; end
        m_stat = 8'h00;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R1, R10: reset state.
        chk("R1 reset data pull", 128'(dut_sda), 128'd0);
        chk("R1 reset alert pull", 128'(dut_alert), 128'd0);
        chk("R10 reset control bytes", cfg_bytes, 128'd0);
        end_txn();
        wq(10);

        // R2: neighbouring address is ignored with all of its bytes.
        begin_txn();
        bus_start();
        put_byte({ADR ^ 7'h01, 1'b0}, ack);
        chk("R2 foreign address no ack", 128'(ack), 128'd0);
        put_byte(8'h15, ack);
        chk("R2 foreign byte no ack", 128'(ack), 128'd0);
        put_byte(8'hAA, ack);
        bus_stop();
        end_txn();
        chk("R2 foreign write ignored", 128'(cfg_bytes[5*8 +: 8]), 128'd0);
        rd_seq(8'h15, 1, "R2");

        // R3, R10: sequential write and read-back.
        wr_seq(8'h11, 3, 8'hA1, 8'hB2, 8'hC3, "R3");
        chk("R10 cfg byte 0x11", 128'(cfg_bytes[1*8 +: 8]), 128'hA1);
        chk("R10 cfg byte 0x13", 128'(cfg_bytes[3*8 +: 8]), 128'hC3);
        rd_seq(8'h11, 3, "R3");

        // R3, R4: wrap from 0x1F into the read-only status byte.
        set_status(8'h40);
        wr_seq(8'h1F, 2, 8'h5E, 8'h77, 8'h00, "R3 wrap");
        rd_seq(8'h1E, 3, "R4 wrap");

        // R5: writes to words are blocked; pointer still advances into 0x10.
        app_put(0, 16'h1357);
        wr_seq(8'h02, 2, 8'hEE, 8'hDD, 8'h00, "R5");
        rd_seq(8'h02, 2, "R5 word unchanged");
        wr_seq(8'h0F, 2, 8'h11, 8'h22, 8'h00, "R5 advance");
        chk("R5 pointer advanced past blocked byte", 128'(cfg_bytes[7:0]), 128'h22);

        // R6: alert follows status AND mask (mask now 0x22).
        set_status(8'h00); wq(6);
        chk("R6 alert off with status 0", 128'(dut_alert), 128'd0);
        set_status(8'h02); wq(6);
        chk("R6 alert on enabled bit", 128'(dut_alert), 128'd1);
        set_status(8'h01); wq(6);
        chk("R6 alert off masked bit", 128'(dut_alert), 128'd0);
        wr_seq(8'h10, 1, 8'h01, 8'h00, 8'h00, "R6 mask");
        wq(6);
        chk("R6 alert on after mask write", 128'(dut_alert), 128'd1);
        rd_seq(8'h00, 1, "R6 status read");

        // R7: all words and both unused read-only gaps.
        app_put(1, 16'hBEEF);
        app_put(2, 16'h0A0B);
        app_put(3, 16'hF00D);
        rd_seq(8'h01, 10, "R7");
        rd_seq(8'h0A, 2, "R7 unused");

        // R8: local update between low and high byte reads.
        app_put(1, 16'hABCD);
        begin_txn();
        bus_start();
        put_byte({ADR, 1'b0}, ack);
        put_byte(8'h04, ack);
        bus_start();
        put_byte({ADR, 1'b1}, ack);
        get_byte(1'b0, v);
        chk("R8 low byte", 128'(v), 128'hCD);
        app_put(1, 16'h1234);
        get_byte(1'b1, v);
        chk("R8 high byte from copy", 128'(v), 128'hAB);
        bus_stop();
        end_txn();
        m_shadow[1] = 8'hAB;
        rd_seq(8'h04, 2, "R8 fresh pair");
        rd_seq(8'h05, 1, "R8 high alone");

        // R9: START mid-byte abandons the byte; pointer kept.
        wr_seq(8'h14, 1, 8'h3C, 8'h00, 8'h00, "R9 setup");
        begin_txn();
        bus_start();
        put_byte({ADR, 1'b0}, ack);
        put_byte(8'h14, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start();
        put_byte({ADR, 1'b1}, ack);
        chk("R9 address after restart", 128'(ack), 128'd1);
        get_byte(1'b1, v);
        chk("R9 byte at kept pointer", 128'(v), 128'h3C);
        bus_stop();
        end_txn();
        chk("R9 no write after restart", 128'(cfg_bytes[4*8 +: 8]), 128'h3C);

        // R9: STOP mid-byte.
        begin_txn();
        bus_start();
        put_byte({ADR, 1'b0}, ack);
        put_byte(8'h16, ack);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_stop();
        end_txn();
        wq(6);
        chk("R9 no write after stop", 128'(cfg_bytes[6*8 +: 8]), 128'h00);
        chk("R1 released after stop", 128'(dut_sda), 128'd0);
        rd_seq(8'h16, 1, "R9");

        wq(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", WDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule